// File: doc/BRIEF.md
# Looping Pattern Generator with Markers

This block plays a stored digital pattern out of a sample memory, one word per clock. The pattern sits at addresses 0 to length-1 of an external synchronous memory with one cycle of read latency. The block drives the read port itself and registers each returned word onto its data output. Software programs the length, the play mode and the repeat count. It also sets up to four marker positions and the trigger polarities, and then pulses `arm`.

There are three play modes. One plays the pattern a single time. Another plays it a programmed number of times. The third loops until `stop` is pulsed. Playback begins either on a chosen edge of the start trigger or, when the trigger is not used, directly after arming. A level-sensitive pause input freezes the read position. A data-active output marks every cycle in which a new sample appears on the data output. Marker outputs pulse together with the samples at their programmed positions. A done pulse marks the last sample of a finite run. Lengths and marker positions work in quanta of four samples, and an illegal configuration is rejected when `arm` is pulsed.

Top module: `pattern_player`

## Requirements
- R1: An `arm` pulse while idle is rejected when any of these holds. The length is not a multiple of 4, is below 4 or is above the memory depth. The mode is loop and the length is below 32. The mode is finite and the repeat count is 0. The mode code is 3. An enabled marker position is not a multiple of 4, or is not below the length. A rejected arm sets `cfg_err` and starts no playback. An accepted arm clears `cfg_err`.
- R2: Mode code 0 (once) plays samples 0 to length-1 in address order, a single time, and then returns to idle.
- R3: Mode code 1 (finite) plays the pattern `cfg_reps` times back to back. The repeat counter holds any value from 1 to 16,777,216.
- R4: Mode code 2 (loop) repeats the pattern until `stop` is pulsed. A stop never produces `done`.
- R5: With `cfg_trig_en` low, the first sample appears on `dout` in the third cycle after the cycle in which `arm` is sampled high. With `cfg_trig_en` high, playback waits for a rising edge of `start_trig`, or a falling edge when `cfg_trig_fall` is 1. The first sample then appears three clock edges after the input changes.
- R6: Pause is active when `pause_trig` XOR `cfg_pause_low` is 1. While pause is active no read is issued and the position is held. After the pause, playback resumes with no sample skipped or repeated.
- R7: `data_active` is high exactly in the cycles in which `dout` carries a newly played sample. It is low while idle, while waiting for a trigger and while paused.
- R8: `dout` keeps the last played sample whenever `data_active` is low.
- R9: `marker[i]` is high for one cycle, together with the sample whose index equals position i, on every pass, when `cfg_mark_en[i]` is 1. Position i is held in bits [8i+7:8i] of `cfg_mark_pos`.
- R10: With no pause, the samples of a finite run leave with no gap, including at the wrap from the last sample back to the first.
- R11: After reset, `dout`, `data_active`, `marker`, `done`, `cfg_err` and `mem_en` are all 0.
- R12: `done` is high for exactly one cycle per finite run, in the cycle of the run's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 9 | Pattern length in samples |
| cfg_reps | input | 25 | Pass count for finite mode |
| cfg_mode | input | 2 | 0 once, 1 finite, 2 loop |
| cfg_trig_en | input | 1 | 1: wait for a start-trigger edge |
| cfg_trig_fall | input | 1 | 1: falling start edge, 0: rising |
| cfg_pause_low | input | 1 | 1: pause active low |
| cfg_mark_pos | input | 32 | Four 8-bit marker positions |
| cfg_mark_en | input | 4 | Per-marker enable |
| arm | input | 1 | Pulse to validate the configuration and arm |
| stop | input | 1 | Pulse to end playback |
| start_trig | input | 1 | Start trigger input |
| pause_trig | input | 1 | Pause trigger input |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| dout | output | 16 | Pattern data output |
| data_active | output | 1 | New sample on `dout` |
| marker | output | 4 | Marker pulses |
| done | output | 1 | Last sample of a finite run |
| cfg_err | output | 1 | Last arm was rejected |

## Verification
The bench goes after the wrap from the last sample to the first. A read pointer that stalls or starts again at 1 there would show up as a gap in `data_active` or a wrong word. Random pause patterns test that a pause holds the read position. A design that let the address advance during a pause would skip words, and one that dropped the in-flight read would repeat them. The bench also checks `done` against the true last sample of multi-pass runs, so an off-by-one in the pass counter would give an early or missing pulse. Each rejection rule of the configuration check is hit one at a time, along with both trigger polarities and the exact start latency.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_FINITE = 2'd1,
    MODE_LOOP   = 2'd2
  } play_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pp_cfg_check.sv
module pp_cfg_check #(
  parameter int ADDR_W   = 8,
  parameter int REP_W    = 25,
  parameter int NUM_MARK = 4,
  parameter int QUANTUM  = 4,
  parameter int MIN_LOOP = 32
) (
  input  logic [ADDR_W:0]          len,
  input  logic [REP_W-1:0]         reps,
  input  logic [1:0]               mode,
  input  logic [NUM_MARK*ADDR_W-1:0] mark_pos,
  input  logic [NUM_MARK-1:0]      mark_en,
  output logic                     cfg_bad
);
  import pp_pkg::*;
  localparam int QBITS = $clog2(QUANTUM);
  localparam logic [ADDR_W:0] LEN_MIN  = (ADDR_W+1)'(QUANTUM);
  localparam logic [ADDR_W:0] LEN_MAX  = (ADDR_W+1)'(1 << ADDR_W);
  localparam logic [ADDR_W:0] LOOP_MIN = (ADDR_W+1)'(MIN_LOOP);

  logic [NUM_MARK-1:0] mark_bad;

  // each enabled marker must sit on a quantum boundary inside the pattern
  for (genvar i = 0; i < NUM_MARK; i++) begin : g_mark
    logic [ADDR_W-1:0] pos;
    assign pos = mark_pos[i*ADDR_W +: ADDR_W];
    assign mark_bad[i] = mark_en[i] &
                         ((pos[QBITS-1:0] != '0) || ({1'b0, pos} >= len));
  end

  always_comb begin
    cfg_bad = |mark_bad;
    if (len[QBITS-1:0] != '0) cfg_bad = 1'b1;
    if (len < LEN_MIN || len > LEN_MAX) cfg_bad = 1'b1;
    case (mode)
      MODE_ONCE:   ;
      MODE_FINITE: if (reps == '0) cfg_bad = 1'b1;
      MODE_LOOP:   if (len < LOOP_MIN) cfg_bad = 1'b1;
      default:     cfg_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pp_trig.sv
module pp_trig (
  input  logic clk,
  input  logic rst,
  input  logic start_in,
  input  logic start_fall,
  input  logic pause_in,
  input  logic pause_low,
  output logic start_edge,
  output logic pause_act
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start_in;
  end

  assign start_edge = start_fall ? (~start_in & start_q) : (start_in & ~start_q);
  assign pause_act  = pause_in ^ pause_low;
endmodule

// File: rtl/pp_seq.sv
module pp_seq #(
  parameter int ADDR_W = 8,
  parameter int REP_W  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              stop,
  input  logic              cfg_bad,
  input  logic              trig_use,
  input  logic              start_edge,
  input  logic              pause_act,
  input  logic [ADDR_W:0]   len,
  input  logic [REP_W-1:0]  reps,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fire,
  output logic              fire_last,
  output logic              idle
);
  import pp_pkg::*;
  seq_state_e       state;
  logic [REP_W-1:0] pass_left;
  logic             at_end;

  assign idle      = (state == ST_IDLE);
  assign fire      = (state == ST_RUN) & ~pause_act & ~stop;
  assign at_end    = ({1'b0, rd_addr} == len - (ADDR_W+1)'(1));
  assign fire_last = fire & at_end & (mode != MODE_LOOP) & (pass_left == REP_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_addr   <= '0;
      pass_left <= '0;
    end else begin
      case (state)
        ST_IDLE: if (arm && !cfg_bad) begin
          rd_addr   <= '0;
          pass_left <= (mode == MODE_FINITE) ? reps : REP_W'(1);
          state     <= trig_use ? ST_WAIT : ST_RUN;
        end
        ST_WAIT: begin
          if (stop)            state <= ST_IDLE;
          else if (start_edge) state <= ST_RUN;
        end
        ST_RUN: begin
          if (stop) state <= ST_IDLE;
          else if (fire) begin
            if (at_end) begin
              rd_addr <= '0;
              if (fire_last)              state     <= ST_IDLE;
              else if (mode != MODE_LOOP) pass_left <= pass_left - REP_W'(1);
            end else begin
              rd_addr <= rd_addr + ADDR_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pattern_player.sv
module pattern_player #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int REP_W    = 25,
  parameter int NUM_MARK = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W:0]            cfg_len,
  input  logic [REP_W-1:0]           cfg_reps,
  input  logic [1:0]                 cfg_mode,
  input  logic                       cfg_trig_en,
  input  logic                       cfg_trig_fall,
  input  logic                       cfg_pause_low,
  input  logic [NUM_MARK*ADDR_W-1:0] cfg_mark_pos,
  input  logic [NUM_MARK-1:0]        cfg_mark_en,
  input  logic                       arm,
  input  logic                       stop,
  input  logic                       start_trig,
  input  logic                       pause_trig,
  output logic                       mem_en,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [DATA_W-1:0]          dout,
  output logic                       data_active,
  output logic [NUM_MARK-1:0]        marker,
  output logic                       done,
  output logic                       cfg_err
);
  logic              cfg_bad, start_edge, pause_act;
  logic              fire, fire_last, seq_idle;
  logic [ADDR_W-1:0] rd_addr;
  logic              v1, v1_last;
  logic [ADDR_W-1:0] v1_idx;
  logic [NUM_MARK-1:0] mark_hit;

  pp_cfg_check #(.ADDR_W(ADDR_W), .REP_W(REP_W), .NUM_MARK(NUM_MARK)) u_chk_cfg (
    .len(cfg_len), .reps(cfg_reps), .mode(cfg_mode),
    .mark_pos(cfg_mark_pos), .mark_en(cfg_mark_en), .cfg_bad(cfg_bad)
  );

  pp_trig u_trig (
    .clk(clk), .rst(rst), .start_in(start_trig), .start_fall(cfg_trig_fall),
    .pause_in(pause_trig), .pause_low(cfg_pause_low),
    .start_edge(start_edge), .pause_act(pause_act)
  );

  pp_seq #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_seq (
    .clk(clk), .rst(rst), .arm(arm), .stop(stop), .cfg_bad(cfg_bad),
    .trig_use(cfg_trig_en), .start_edge(start_edge), .pause_act(pause_act),
    .len(cfg_len), .reps(cfg_reps), .mode(cfg_mode),
    .rd_addr(rd_addr), .fire(fire), .fire_last(fire_last), .idle(seq_idle)
  );

  assign mem_en   = fire;
  assign mem_addr = rd_addr;

  // marker compare against the index of the word in flight
  for (genvar i = 0; i < NUM_MARK; i++) begin : g_mark
    assign mark_hit[i] = cfg_mark_en[i] & (v1_idx == cfg_mark_pos[i*ADDR_W +: ADDR_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1          <= 1'b0;
      v1_idx      <= '0;
      v1_last     <= 1'b0;
      dout        <= '0;
      data_active <= 1'b0;
      marker      <= '0;
      done        <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      v1          <= fire;
      v1_idx      <= rd_addr;
      v1_last     <= fire_last;
      data_active <= v1;
      done        <= v1 & v1_last;
      marker      <= v1 ? mark_hit : '0;
      if (v1) dout <= mem_rdata;
      if (arm && seq_idle) cfg_err <= cfg_bad;
    end
  end
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int DATA_W   = 16,
  parameter int NUM_MARK = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                arm,
  input logic                cfg_bad,
  input logic                seq_idle,
  input logic                pause_act,
  input logic                mem_en,
  input logic [DATA_W-1:0]   dout,
  input logic                data_active,
  input logic [NUM_MARK-1:0] marker,
  input logic                done,
  input logic                cfg_err
);
  p_bad_arm_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (arm && seq_idle && cfg_bad) |=> (seq_idle && cfg_err));

  p_pause_no_read_r6: assert property (@(posedge clk) disable iff (rst)
    pause_act |-> !mem_en);

  p_active_from_read_r7: assert property (@(posedge clk) disable iff (rst)
    data_active |-> $past(mem_en, 2));

  p_hold_when_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !data_active |-> $stable(dout));

  p_marker_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (marker & $past(marker)) == '0);

  p_marker_with_data_r9: assert property (@(posedge clk) disable iff (rst)
    (|marker) |-> data_active);

  p_done_with_data_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> data_active);

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind pattern_player pp_checker #(.DATA_W(DATA_W), .NUM_MARK(NUM_MARK)) u_pp_checker (
  .clk(clk), .rst(rst), .arm(arm), .cfg_bad(cfg_bad), .seq_idle(seq_idle),
  .pause_act(pause_act), .mem_en(mem_en), .dout(dout), .data_active(data_active),
  .marker(marker), .done(done), .cfg_err(cfg_err)
);

// File: tb/tb_pattern_player.sv
module tb_pattern_player;
  localparam int DW = 16, AW = 8, RW = 25, NM = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic [AW:0] cfg_len = 0;
  logic [RW-1:0] cfg_reps = 0;
  logic [1:0] cfg_mode = 0;
  logic cfg_trig_en = 0, cfg_trig_fall = 0, cfg_pause_low = 0;
  logic [NM*AW-1:0] cfg_mark_pos = 0;
  logic [NM-1:0] cfg_mark_en = 0;
  logic arm = 0, stop = 0, start_trig = 0, pause_trig = 0;
  logic mem_en; logic [AW-1:0] mem_addr; logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dout; logic data_active, done, cfg_err; logic [NM-1:0] marker;

  logic [DW-1:0] pat [DEPTH];
  int chk = 0, errs = 0, cyc = 0;
  int exp_len = 4, exp_total = 0, exp_idx = 0;
  bit gap_watch = 0;
  logic [DW-1:0] last_dout = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  pattern_player #(.DATA_W(DW), .ADDR_W(AW), .REP_W(RW), .NUM_MARK(NM)) dut (.*);

  always_ff @(posedge clk) if (mem_en) mem_rdata <= pat[mem_addr];

  task automatic fail(string req, string what, int act, int expv);
    errs++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
  endtask

  // sample stream monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk++;
      if (data_active) begin
        logic [NM-1:0] em;
        int pos;
        pos = exp_idx % exp_len;
        if (exp_total >= 0 && exp_idx >= exp_total) fail("R7", "extra sample", exp_idx, exp_total);
        else begin
          if (dout != pat[pos]) fail(cur_req, "sample", dout, pat[pos]);
          for (int i = 0; i < NM; i++)
            em[i] = cfg_mark_en[i] && (cfg_mark_pos[i*AW +: AW] == pos);
          if (marker != em) fail("R9", "marker", marker, em);
          if (done != (exp_total > 0 && exp_idx == exp_total - 1))
            fail("R12", "done", done, !done);
        end
        exp_idx++;
        last_dout = dout;
      end else begin
        if (dout != last_dout) fail("R8", "hold", dout, last_dout);
        if (done) fail("R12", "done without sample", 1, 0);
        if (marker != 0) fail("R9", "marker idle", marker, 0);
        if (gap_watch && exp_idx > 0 && exp_idx < exp_total) fail("R10", "gap", exp_idx, exp_total);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", chk, errs);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic do_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic setup(int len, int mode, int reps, bit ten, bit fall, bit plow, bit marks);
    cfg_len = (AW+1)'(len); cfg_mode = 2'(mode); cfg_reps = RW'(reps);
    cfg_trig_en = ten; cfg_trig_fall = fall; cfg_pause_low = plow;
    pause_trig = plow; start_trig = fall;
    cfg_mark_en = marks ? NM'($urandom) : '0;
    for (int i = 0; i < NM; i++) cfg_mark_pos[i*AW +: AW] = AW'(($urandom % (len/4)) * 4);
    exp_len = len; exp_idx = 0;
    exp_total = (mode == 2) ? -1 : ((mode == 1) ? len * reps : len);
  endtask

  task automatic play(int len, int mode, int reps, bit ten, bit fall, bit plow, int pprob, string req);
    int t;
    cur_req = req;
    setup(len, mode, reps, ten, fall, plow, 1);
    gap_watch = (pprob == 0);
    do_arm();
    if (ten) begin tick(3); start_trig = ~fall; end
    t = 0;
    while (exp_idx < exp_total && t < 20000) begin
      @(negedge clk);
      pause_trig = (($urandom % 100) < pprob) ^ plow;
      t++;
    end
    pause_trig = plow; gap_watch = 0;
    tick(5);
    chk++; if (exp_idx != exp_total) fail(req, "sample count", exp_idx, exp_total);
    chk++; if (data_active) fail("R7", "active after run", 1, 0);
  endtask

  task automatic bad_arm(int len, int mode, int reps, int mpos);
    setup(len, mode, reps, 0, 0, 0, 0);
    if (mpos >= 0) begin cfg_mark_en = 4'b0001; cfg_mark_pos[AW-1:0] = AW'(mpos); end
    exp_total = 0;
    do_arm(); tick(6);
    chk++; if (cfg_err !== 1'b1) fail("R1", "cfg_err", cfg_err, 1);
    chk++; if (data_active) fail("R1", "started on bad config", 1, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) pat[i] = DW'($urandom);
    tick(5); rst = 0; @(negedge clk);
    // R11 reset state
    chk++; if (dout != 0 || data_active || marker != 0 || done || cfg_err || mem_en)
      fail("R11", "reset state", {dout, data_active, marker, done, cfg_err, mem_en}, 0);

    // R5 latency, trigger unused
    setup(8, 0, 1, 0, 0, 0, 0); cur_req = "R2";
    do_arm(); @(negedge clk);
    chk++; if (data_active) fail("R5", "early start", 1, 0);
    @(negedge clk);
    chk++; if (!data_active) fail("R5", "start latency", 0, 1);
    tick(12);

    // R5 latency, rising then falling trigger
    for (int f = 0; f < 2; f++) begin
      setup(8, 0, 1, 1, f[0], 0, 0);
      do_arm(); tick(6);
      chk++; if (data_active) fail("R5", "ran before trigger", 1, 0);
      start_trig = ~start_trig;
      tick(2);
      chk++; if (data_active) fail("R5", "trigger early", 1, 0);
      @(negedge clk);
      chk++; if (!data_active) fail("R5", "trigger latency", 0, 1);
      tick(12);
    end

    // R1 rejection rules, one at a time
    bad_arm(6, 0, 1, -1);
    bad_arm(0, 0, 1, -1);
    bad_arm(260, 0, 1, -1);
    bad_arm(16, 2, 1, -1);
    bad_arm(16, 1, 0, -1);
    bad_arm(16, 3, 1, -1);
    bad_arm(16, 0, 1, 2);
    bad_arm(16, 0, 1, 16);
    // boundary: accepted arm clears the flag
    play(4, 0, 1, 0, 0, 0, 0, "R2");
    chk++; if (cfg_err) fail("R1", "cfg_err not cleared", 1, 0);

    // directed: full depth, wrap continuity, finite passes
    play(DEPTH, 0, 1, 0, 0, 0, 0, "R2");
    play(12, 1, 5, 0, 0, 0, 0, "R10");
    play(32, 1, 3, 1, 1, 1, 30, "R6");

    // R4 loop with stop
    cur_req = "R4";
    setup(32, 2, 1, 0, 0, 0, 1);
    do_arm();
    for (int t = 0; t < 300; t++) begin
      @(negedge clk); pause_trig = (($urandom % 100) < 20);
    end
    pause_trig = 0; stop = 1; @(negedge clk); stop = 0; tick(5);
    chk++; if (exp_idx <= 32) fail("R4", "no wrap in loop", exp_idx, 33);
    chk++; if (data_active) fail("R4", "still running after stop", 1, 0);

    // random runs
    for (int r = 0; r < 14; r++) begin
      int len, mode, reps;
      mode = $urandom % 2;
      len = (($urandom % (DEPTH/4)) + 1) * 4;
      reps = (mode == 1) ? ($urandom % 4) + 1 : 1;
      play(len, mode, reps, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 3 == 0) ? 0 : $urandom % 40, (mode == 1) ? "R3" : "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", chk, errs);
    $finish;
  end
endmodule